// File: doc/BRIEF.md
# Fast Interrupt Context Shadow Bank

This block holds four working registers and a status word for a processor core. Next to them it keeps one shadow copy. When an interrupt marked fast is accepted, all four working registers and a chosen subset of status bits are copied into the shadow copy on a single clock edge. When the return strobe arrives, the copy is written back on a single edge. Nothing goes through the memory stack on either path.

There is only one shadow copy, so a fast context cannot nest. A busy bit records that the shadow copy holds a live context. A second fast entry while that bit is set is flagged and does not overwrite the saved copy. A return with nothing saved is also flagged, and it changes nothing. The block does not arbitrate priority. The system must send fast entries only when every interrupt shares one level, or only for the top level. Slow, stack-based entries pass through without touching the shadow copy.

Top module: `fast_ctx_save`

## Requirements
- R1: After reset, all four registers and the status word read zero, and busy_o, nest_err_o and orphan_err_o are low.
- R2: A write with wr_en_i high loads wr_data_i into the register selected by wr_addr_i (0 to 3) on the next edge. A write with stat_wr_i high loads stat_data_i into the status word. reg_o holds register n in bits [16n+15:16n].
- R3: A fast entry (irq_take_i and irq_fast_i high) while busy_o is low captures the four registers and the status bits selected by SAVE_MASK into the shadow copy, and sets busy_o on the next edge.
- R4: A return (irq_ret_i high) while busy_o is high restores all four registers and the saved status bits from the shadow copy on one edge, and clears busy_o.
- R5: Status bits whose SAVE_MASK bit is 0 (bits 7:6 with the default mask 8'h3F) keep their live value across a restore.
- R6: A fast entry while busy_o is high sets nest_err_o. The shadow copy stays unchanged and busy_o stays high.
- R7: A return while busy_o is low leaves the registers and status unchanged and sets orphan_err_o.
- R8: An entry with irq_fast_i low has no effect on busy_o or the shadow copy.
- R9: When a register write and a fast entry fall in the same cycle, the shadow copy takes the value from before the write, and the register takes the new value.
- R10: When a register write and a restore fall in the same cycle, the restore wins for that register.
- R11: When a fast entry and a return fall in the same cycle, each is judged against busy_o before that edge. If the block is idle, the entry saves and the return is flagged as an orphan. If it is busy, the return restores and clears busy_o, and the entry is flagged as nested.
- R12: nest_err_o and orphan_err_o stay high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write enable |
| wr_addr_i | input | 2 | Register select |
| wr_data_i | input | 16 | Register write data |
| stat_wr_i | input | 1 | Status write enable |
| stat_data_i | input | 8 | Status write data |
| irq_take_i | input | 1 | Interrupt accepted pulse |
| irq_fast_i | input | 1 | Accepted interrupt uses the shadow copy |
| irq_ret_i | input | 1 | Return-from-interrupt pulse |
| reg_o | output | 64 | Four working registers, packed |
| status_o | output | 8 | Live status word |
| busy_o | output | 1 | Shadow copy holds a context |
| nest_err_o | output | 1 | Sticky: fast entry while busy |
| orphan_err_o | output | 1 | Sticky: return while idle |

## Verification
The write port can land in the same cycle as a fast save or as a restore. The bench provokes both on purpose. It writes register 0 in the cycle a fast entry is accepted, then checks that the register shows the new value. It then writes register 0 again in the cycle of the return, and checks that the register comes back to its value from before the first write. That value proves the save took the old contents and that the restore won over the write. Entry and return are also raised together, once with the block idle and once with it busy. The bench then judges busy_o, the flags and a register that was changed on purpose in between.

// File: rtl/ctx_pkg.sv
package ctx_pkg;
  localparam int unsigned CTX_NUM_REGS = 4;

  typedef struct packed {
    logic save;
    logic restore;
  } ctx_cmd_t;
endpackage

// File: rtl/ctx_ctrl.sv
module ctx_ctrl
  import ctx_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     take_i,
  input  logic     fast_i,
  input  logic     ret_i,
  output ctx_cmd_t cmd_o,
  output logic     busy_o,
  output logic     nest_err_o,
  output logic     orphan_err_o
);
  logic busy_q, nest_q, orphan_q;
  logic fast_take;

  assign fast_take     = take_i & fast_i;
  assign cmd_o.save    = fast_take & ~busy_q;
  assign cmd_o.restore = ret_i & busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q   <= 1'b0;
      nest_q   <= 1'b0;
      orphan_q <= 1'b0;
    end else begin
      // both strobes are judged against busy before the edge
      if (cmd_o.restore)   busy_q <= 1'b0;
      else if (cmd_o.save) busy_q <= 1'b1;
      if (fast_take && busy_q) nest_q   <= 1'b1;
      if (ret_i && !busy_q)    orphan_q <= 1'b1;
    end
  end

  assign busy_o       = busy_q;
  assign nest_err_o   = nest_q;
  assign orphan_err_o = orphan_q;

  // R3
  busy_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_i && fast_i && !busy_q) |=> busy_q);
  // R6
  nest_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_i && fast_i && busy_q && !ret_i) |=> (nest_q && busy_q));
  // R8
  slow_entry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_i && !fast_i && !ret_i) |=> $stable(busy_q));
  // R12
  sticky_err_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (nest_q || orphan_q) |=> ((nest_q || !$past(nest_q)) && (orphan_q || !$past(orphan_q))));
endmodule

// File: rtl/ctx_shadow.sv
module ctx_shadow #(
  parameter int unsigned DATA_W   = 16,
  parameter int unsigned NUM_REGS = 4,
  parameter int unsigned STAT_W   = 8,
  parameter logic [STAT_W-1:0] SAVE_MASK = 8'h3F
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       save_i,
  input  logic [NUM_REGS*DATA_W-1:0] regs_i,
  input  logic [STAT_W-1:0]          stat_i,
  output logic [NUM_REGS*DATA_W-1:0] shd_regs_o,
  output logic [STAT_W-1:0]          shd_stat_o
);
  for (genvar i = 0; i < NUM_REGS; i++) begin : g_slot
    logic [DATA_W-1:0] slot_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     slot_q <= '0;
      else if (save_i) slot_q <= regs_i[i*DATA_W +: DATA_W];
    end
    assign shd_regs_o[i*DATA_W +: DATA_W] = slot_q;
  end

  logic [STAT_W-1:0] stat_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     stat_q <= '0;
    else if (save_i) stat_q <= stat_i & SAVE_MASK;
  end
  assign shd_stat_o = stat_q;
endmodule

// File: rtl/ctx_workfile.sv
module ctx_workfile #(
  parameter int unsigned DATA_W   = 16,
  parameter int unsigned NUM_REGS = 4,
  parameter int unsigned STAT_W   = 8,
  parameter logic [STAT_W-1:0] SAVE_MASK = 8'h3F,
  localparam int unsigned AW = $clog2(NUM_REGS)
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       wr_en_i,
  input  logic [AW-1:0]              wr_addr_i,
  input  logic [DATA_W-1:0]          wr_data_i,
  input  logic                       stat_wr_i,
  input  logic [STAT_W-1:0]          stat_data_i,
  input  logic                       restore_i,
  input  logic [NUM_REGS*DATA_W-1:0] shd_regs_i,
  input  logic [STAT_W-1:0]          shd_stat_i,
  output logic [NUM_REGS*DATA_W-1:0] regs_o,
  output logic [STAT_W-1:0]          stat_o
);
  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    logic [DATA_W-1:0] reg_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                               reg_q <= '0;
      else if (restore_i)                        reg_q <= shd_regs_i[i*DATA_W +: DATA_W];
      else if (wr_en_i && wr_addr_i == AW'(i))   reg_q <= wr_data_i;
    end
    assign regs_o[i*DATA_W +: DATA_W] = reg_q;
  end

  logic [STAT_W-1:0] stat_q, stat_live, stat_d;
  always_comb begin
    stat_live = stat_wr_i ? stat_data_i : stat_q;
    stat_d    = restore_i ? ((shd_stat_i & SAVE_MASK) | (stat_live & ~SAVE_MASK)) : stat_live;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stat_q <= '0;
    else         stat_q <= stat_d;
  end
  assign stat_o = stat_q;
endmodule

// File: rtl/fast_ctx_save.sv
module fast_ctx_save
  import ctx_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned STAT_W = 8,
  parameter logic [STAT_W-1:0] SAVE_MASK = 8'h3F,
  localparam int unsigned NUM_REGS = CTX_NUM_REGS,
  localparam int unsigned AW = $clog2(NUM_REGS)
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       wr_en_i,
  input  logic [AW-1:0]              wr_addr_i,
  input  logic [DATA_W-1:0]          wr_data_i,
  input  logic                       stat_wr_i,
  input  logic [STAT_W-1:0]          stat_data_i,
  input  logic                       irq_take_i,
  input  logic                       irq_fast_i,
  input  logic                       irq_ret_i,
  output logic [NUM_REGS*DATA_W-1:0] reg_o,
  output logic [STAT_W-1:0]          status_o,
  output logic                       busy_o,
  output logic                       nest_err_o,
  output logic                       orphan_err_o
);
  ctx_cmd_t                   cmd;
  logic [NUM_REGS*DATA_W-1:0] shd_regs;
  logic [STAT_W-1:0]          shd_stat;

  ctx_ctrl u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .take_i       (irq_take_i),
    .fast_i       (irq_fast_i),
    .ret_i        (irq_ret_i),
    .cmd_o        (cmd),
    .busy_o       (busy_o),
    .nest_err_o   (nest_err_o),
    .orphan_err_o (orphan_err_o)
  );

  ctx_shadow #(
    .DATA_W(DATA_W), .NUM_REGS(NUM_REGS), .STAT_W(STAT_W), .SAVE_MASK(SAVE_MASK)
  ) u_shadow (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .save_i     (cmd.save),
    .regs_i     (reg_o),
    .stat_i     (status_o),
    .shd_regs_o (shd_regs),
    .shd_stat_o (shd_stat)
  );

  ctx_workfile #(
    .DATA_W(DATA_W), .NUM_REGS(NUM_REGS), .STAT_W(STAT_W), .SAVE_MASK(SAVE_MASK)
  ) u_work (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_en_i     (wr_en_i),
    .wr_addr_i   (wr_addr_i),
    .wr_data_i   (wr_data_i),
    .stat_wr_i   (stat_wr_i),
    .stat_data_i (stat_data_i),
    .restore_i   (cmd.restore),
    .shd_regs_i  (shd_regs),
    .shd_stat_i  (shd_stat),
    .regs_o      (reg_o),
    .stat_o      (status_o)
  );

  // R4
  restore_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_ret_i && busy_o) |=> ((reg_o == $past(shd_regs)) && !busy_o));
  // R5
  live_bits_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_ret_i && busy_o && !stat_wr_i) |=>
      ((status_o & ~SAVE_MASK) == ($past(status_o) & ~SAVE_MASK)));
  // R6
  ctx_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_take_i && irq_fast_i && busy_o) |=> ($stable(shd_regs) && $stable(shd_stat)));
  // R7
  orphan_ignore_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_ret_i && !busy_o && !wr_en_i && !stat_wr_i) |=>
      ($stable(reg_o) && $stable(status_o) && orphan_err_o));
  // R9
  save_prewrite_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_take_i && irq_fast_i && !busy_o) |=> (shd_regs == $past(reg_o)));
endmodule

// File: tb/fast_ctx_save_bench.sv
module fast_ctx_save_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [1:0]  wr_addr_i = '0;
  logic [15:0] wr_data_i = '0;
  logic        stat_wr_i = 1'b0;
  logic [7:0]  stat_data_i = '0;
  logic        irq_take_i = 1'b0;
  logic        irq_fast_i = 1'b0;
  logic        irq_ret_i = 1'b0;
  logic [63:0] reg_o;
  logic [7:0]  status_o;
  logic        busy_o, nest_err_o, orphan_err_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2 clk_i = ~clk_i;

  fast_ctx_save u_fast_ctx_save (
    .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i, .stat_wr_i, .stat_data_i,
    .irq_take_i, .irq_fast_i, .irq_ret_i, .reg_o, .status_o, .busy_o,
    .nest_err_o, .orphan_err_o
  );

  // {en, addr, data, expected value at addr afterwards}
  localparam logic [34:0] WR_TAB [8] = '{
    {1'b1, 2'd0, 16'h0101, 16'h0101},
    {1'b1, 2'd1, 16'h0202, 16'h0202},
    {1'b1, 2'd2, 16'h0303, 16'h0303},
    {1'b1, 2'd3, 16'h0404, 16'h0404},
    {1'b0, 2'd0, 16'hFFFF, 16'h0101},
    {1'b1, 2'd0, 16'hBEEF, 16'hBEEF},
    {1'b1, 2'd3, 16'h0000, 16'h0000},
    {1'b0, 2'd1, 16'h7777, 16'h0202}
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk_i);
    wr_en_i = 1'b0; stat_wr_i = 1'b0;
    irq_take_i = 1'b0; irq_fast_i = 1'b0; irq_ret_i = 1'b0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d;
    cyc();
  endtask

  function automatic logic [15:0] rd(input int a);
    return reg_o[a*16 +: 16];
  endfunction

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    logic [63:0] set_a;
    repeat (2) @(negedge clk_i);
    // R1 reset state
    chk("R1 regs", reg_o, 64'h0);
    chk("R1 flags", {56'h0, status_o}, 64'h0);
    chk("R1 busy/err", {61'h0, busy_o, nest_err_o, orphan_err_o}, 64'h0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R2 vector walk
    for (int i = 0; i < 8; i++) begin
      wr_en_i = WR_TAB[i][34]; wr_addr_i = WR_TAB[i][33:32]; wr_data_i = WR_TAB[i][31:16];
      cyc();
      chk("R2 table", {48'h0, rd(int'(WR_TAB[i][33:32]))}, {48'h0, WR_TAB[i][15:0]});
    end

    for (int i = 0; i < 4; i++) wr(2'(i), 16'h1000 + 16'(i));
    stat_wr_i = 1'b1; stat_data_i = 8'hA5; cyc();
    set_a = {16'h1003, 16'h1002, 16'h1001, 16'h1000};
    chk("R2 regs", reg_o, set_a);
    chk("R2 status", {56'h0, status_o}, 64'hA5);

    // R8 slow entry while idle
    irq_take_i = 1'b1; cyc();
    chk("R8 idle busy", {63'h0, busy_o}, 64'h0);

    // R3 fast entry
    irq_take_i = 1'b1; irq_fast_i = 1'b1; cyc();
    chk("R3 busy", {63'h0, busy_o}, 64'h1);

    for (int i = 0; i < 4; i++) wr(2'(i), 16'h2000 + 16'(i));
    stat_wr_i = 1'b1; stat_data_i = 8'h5A; cyc();

    // R8 slow entry while busy
    irq_take_i = 1'b1; cyc();
    chk("R8 busy held", {62'h0, busy_o, nest_err_o}, 64'h2);

    // R6 nested fast entry
    irq_take_i = 1'b1; irq_fast_i = 1'b1; cyc();
    chk("R6 nest flag", {62'h0, busy_o, nest_err_o}, 64'h3);
    chk("R6 live regs", reg_o, {16'h2003, 16'h2002, 16'h2001, 16'h2000});

    // R4/R5 restore
    irq_ret_i = 1'b1; cyc();
    chk("R4 regs", reg_o, set_a);
    chk("R5 status", {56'h0, status_o}, 64'h65);
    chk("R4 busy", {62'h0, busy_o, orphan_err_o}, 64'h0);

    // R9 write with fast entry
    wr_en_i = 1'b1; wr_addr_i = 2'd0; wr_data_i = 16'h1111;
    irq_take_i = 1'b1; irq_fast_i = 1'b1; cyc();
    chk("R9 reg0 new", {48'h0, rd(0)}, 64'h1111);
    chk("R9 busy", {63'h0, busy_o}, 64'h1);

    // R10 write with restore
    wr_en_i = 1'b1; wr_addr_i = 2'd0; wr_data_i = 16'h2222;
    irq_ret_i = 1'b1; cyc();
    chk("R10 reg0 restored", {48'h0, rd(0)}, 64'h1000);
    chk("R10 busy", {63'h0, busy_o}, 64'h0);

    // R7 orphan return
    irq_ret_i = 1'b1; cyc();
    chk("R7 regs unchanged", reg_o, set_a);
    chk("R7 status unchanged", {56'h0, status_o}, 64'h65);
    chk("R7 orphan flag", {63'h0, orphan_err_o}, 64'h1);

    // R11 entry+return while idle: entry saves
    irq_take_i = 1'b1; irq_fast_i = 1'b1; irq_ret_i = 1'b1; cyc();
    chk("R11 idle both busy", {63'h0, busy_o}, 64'h1);
    chk("R11 idle both regs", reg_o, set_a);
    wr(2'd1, 16'hCAFE);
    chk("R11 reg1 changed", {48'h0, rd(1)}, 64'hCAFE);
    // R11 entry+return while busy: return restores
    irq_take_i = 1'b1; irq_fast_i = 1'b1; irq_ret_i = 1'b1; cyc();
    chk("R11 busy both reg1", {48'h0, rd(1)}, 64'h1001);
    chk("R11 busy both busy", {63'h0, busy_o}, 64'h0);

    // R12 sticky flags
    repeat (3) cyc();
    chk("R12 sticky", {62'h0, nest_err_o, orphan_err_o}, 64'h3);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule